// File: doc/BRIEF.md
# Packet-to-Cache-Block Address Tagger

This block sits on the receive path of one DMA channel when packet data goes to an external processing engine instead of to memory. It takes a byte stream that carries start, end and error marks. It packs the bytes into 32-byte cache blocks and sends each block out as a single wide write. The write address of each block carries all the information about that block: the 1 MB region base, the channel number, the block's position in its packet, and, on the final block, how many of its bytes are valid.

Software can turn on a prepend mode. In this mode, the first doubleword of the packet's descriptor is placed at the front of the first block, ahead of the packet data. The engine can then learn from it where the processed result should go. The 5-bit offset field in that word is always sent as zero.

The input and the output both use valid/ready handshakes. While a finished block waits at the output, the input is held off. The configuration inputs are expected to stay steady while a packet is in flight.

Top module: `pkt_block_tagger`

## Requirements
- R1: Address bits [10:0] of every emitted block are zero.
- R2: Address bits [39:20] equal `cfgBase[39:20]`, and bits [19:18] equal `cfgChannel`.
- R3: Address bits [17:16] give the block's position in its packet. 01 marks the first block of a packet that spans more than one block. 00 marks a middle block. 10 marks the last block of a packet whose last byte had `inError` low. 11 marks the last block of a packet whose last byte had `inError` high.
- R4: On a last block (type 10 or 11), address bits [15:11] hold the number of valid bytes in the block, counted modulo 32, so a full block reads 0. On type 00 and 01 blocks these bits are 0.
- R5: A packet whose bytes fit in one block produces exactly one block, and that block has an end type (10 or 11), never 01.
- R6: Byte i of a block (i = 0..31) appears on `outData[8i+7:8i]`, and valid bytes are packed from byte 0 upward. Bytes beyond the valid count of a last block are zero.
- R7: When `cfgPrependEn` is 1 at a packet's first byte, bytes 0..7 of the first block carry `cfgDesc`, least significant byte first, with `cfgDesc[4:0]` forced to zero. Packet data starts at byte 8. The descriptor bytes count toward block filling and toward the valid count.
- R8: When `cfgPrependEn` is 0, packet data starts at byte 0 of the first block, and `cfgDesc` has no effect on any output.
- R9: While `outValid` is 1 and `outReady` is 0, `outAddr` and `outData` hold steady and `inReady` is 0. No accepted byte is lost or duplicated.
- R10: A byte accepted while no packet is open, and without `inFirst`, is discarded and does not appear in any block.
- R11: After reset, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBase | input | 40 | Region base; only bits [39:20] are used |
| cfgChannel | input | 2 | DMA channel number placed in the address |
| cfgPrependEn | input | 1 | Put the descriptor doubleword in front of the packet data |
| cfgDesc | input | 64 | Descriptor doubleword for the current packet |
| inValid | input | 1 | Input byte valid |
| inReady | output | 1 | Input byte accepted when high together with inValid |
| inData | input | 8 | Input byte |
| inFirst | input | 1 | Byte is the first of a packet |
| inLast | input | 1 | Byte is the last of a packet |
| inError | input | 1 | Packet ended in error (read with inLast) |
| outValid | output | 1 | A block is presented |
| outReady | input | 1 | Block is taken when high together with outValid |
| outAddr | output | 40 | Tagged block write address |
| outData | output | 256 | Block data, byte 0 in the low bits |

## Verification
The assertions check the following on every cycle: the address format (zero low bits, base and channel placement, a zero count field on start and middle blocks), zero fill after the valid bytes of a last block, and the stall rules, meaning a held block stays steady and no byte enters while a block waits.

Some behaviours can only be shown by the bench scenarios, because they depend on the byte stream as a whole. These are the order in which block types appear across a packet, the promotion of a one-block packet to an end type, the exact valid count at 32-byte boundaries, the placement of the prepended descriptor, and the dropping of stray bytes outside a packet.

// File: rtl/tagger_pkg.sv
package tagger_pkg;
  // One cache block, the descriptor word, and widths derived from them.
  parameter int BLK_BYTES  = 32;
  parameter int DESC_W     = 64;
  localparam int IDX_W      = $clog2(BLK_BYTES);
  localparam int CNT_W      = IDX_W + 1;
  localparam int DESC_BYTES = DESC_W / 8;
  localparam int BLK_W      = BLK_BYTES * 8;

  typedef enum logic [1:0] {
    BT_MID = 2'b00,
    BT_SOP = 2'b01,
    BT_EOP = 2'b10,
    BT_ERR = 2'b11
  } blkType_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic             wrByte;
    logic [IDX_W-1:0] wrIdx;
    logic             loadDesc;
    logic             clearBuf;
    logic             loadAddr;
    blkType_e         blkType;
    logic [IDX_W-1:0] blkCount;
  } tagStrobes_t;
endpackage

// File: rtl/tagger_ctrl.sv
module tagger_ctrl
  import tagger_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgPrependEn,
  input  logic        inValid,
  input  logic        inFirst,
  input  logic        inLast,
  input  logic        inError,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output tagStrobes_t strb
);
  logic             inPkt;
  logic             sopPend;
  logic [CNT_W-1:0] fill;
  logic             outValidQ;

  logic             accept;
  logic             start;
  logic             keep;
  logic [CNT_W-1:0] basePos;
  logic [CNT_W-1:0] nextFill;
  logic             blkFull;
  logic             emit;
  logic             sopNow;

  assign inReady  = !outValidQ;
  assign outValid = outValidQ;

  always_comb begin
    accept   = inValid && !outValidQ;
    // A first mark opens a packet only while none is open.
    start    = accept && !inPkt && inFirst;
    // Bytes outside a packet are taken and dropped.
    keep     = accept && (inPkt || inFirst);
    if (start)
      basePos = cfgPrependEn ? CNT_W'(DESC_BYTES) : '0;
    else
      basePos = fill;
    nextFill = basePos + CNT_W'(1);
    blkFull  = (nextFill == CNT_W'(BLK_BYTES));
    emit     = keep && (inLast || blkFull);
    sopNow   = start || sopPend;

    strb.wrByte   = keep;
    strb.wrIdx    = basePos[IDX_W-1:0];
    strb.loadDesc = start && cfgPrependEn;
    strb.clearBuf = outValidQ && outReady;
    strb.loadAddr = emit;
    // End position wins over start position.
    if (inLast)
      strb.blkType = inError ? BT_ERR : BT_EOP;
    else if (sopNow)
      strb.blkType = BT_SOP;
    else
      strb.blkType = BT_MID;
    // Modulo count: a full last block wraps to zero.
    strb.blkCount = inLast ? nextFill[IDX_W-1:0] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      sopPend   <= 1'b0;
      fill      <= '0;
      outValidQ <= 1'b0;
    end else begin
      if (strb.clearBuf)
        outValidQ <= 1'b0;
      if (keep) begin
        if (emit) begin
          outValidQ <= 1'b1;
          fill      <= '0;
          sopPend   <= 1'b0;
          inPkt     <= !inLast;
        end else begin
          fill      <= nextFill;
          sopPend   <= sopNow;
          inPkt     <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tagger_datapath.sv
module tagger_datapath
  import tagger_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int BASE_LSB = 20,
  parameter int CHAN_W   = 2,
  parameter int OFS_LSB  = 0,
  parameter int OFS_W    = 5
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tagStrobes_t                strb,
  input  logic [7:0]                 inData,
  input  logic [ADDR_W-1:BASE_LSB]   baseHi,
  input  logic [CHAN_W-1:0]          cfgChannel,
  input  logic [DESC_W-1:0]          cfgDesc,
  output logic [ADDR_W-1:0]          outAddr,
  output logic [BLK_W-1:0]           outData
);
  localparam int TYPE_W   = 2;
  localparam int LOW_ZERO = BASE_LSB - CHAN_W - TYPE_W - IDX_W;
  localparam logic [DESC_W-1:0] OFS_MASK =
    ((DESC_W'(1) << OFS_W) - DESC_W'(1)) << OFS_LSB;

  logic [DESC_W-1:0] descClean;
  logic [7:0]        byteQ [BLK_BYTES];
  logic [ADDR_W-1:0] addrQ;

  // The offset field is not meaningful downstream; send zeros.
  assign descClean = cfgDesc & ~OFS_MASK;

  for (genvar g = 0; g < BLK_BYTES; g++) begin : g_lane
    if (g < DESC_BYTES) begin : g_descLane
      always_ff @(posedge clk) begin
        if (!rstN)
          byteQ[g] <= '0;
        else if (strb.clearBuf)
          byteQ[g] <= '0;
        else if (strb.wrByte && strb.wrIdx == IDX_W'(g))
          byteQ[g] <= inData;
        else if (strb.loadDesc)
          byteQ[g] <= descClean[8*g +: 8];
      end
    end else begin : g_dataLane
      always_ff @(posedge clk) begin
        if (!rstN)
          byteQ[g] <= '0;
        else if (strb.clearBuf)
          byteQ[g] <= '0;
        else if (strb.wrByte && strb.wrIdx == IDX_W'(g))
          byteQ[g] <= inData;
      end
    end
    assign outData[8*g +: 8] = byteQ[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      addrQ <= '0;
    else if (strb.loadAddr)
      addrQ <= {baseHi, cfgChannel, strb.blkType, strb.blkCount,
                {LOW_ZERO{1'b0}}};
  end

  assign outAddr = addrQ;
endmodule

// File: rtl/pkt_block_tagger.sv
module pkt_block_tagger
  import tagger_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int BASE_LSB = 20,
  parameter int CHAN_W   = 2,
  parameter int OFS_LSB  = 0,
  parameter int OFS_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cfgBase,
  input  logic [CHAN_W-1:0] cfgChannel,
  input  logic              cfgPrependEn,
  input  logic [63:0]       cfgDesc,
  input  logic              inValid,
  output logic              inReady,
  input  logic [7:0]        inData,
  input  logic              inFirst,
  input  logic              inLast,
  input  logic              inError,
  output logic              outValid,
  input  logic              outReady,
  output logic [ADDR_W-1:0] outAddr,
  output logic [255:0]      outData
);
  tagStrobes_t strb;
  logic        unusedBaseLow;

  assign unusedBaseLow = ^cfgBase[BASE_LSB-1:0];

  tagger_ctrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfgPrependEn (cfgPrependEn),
    .inValid      (inValid),
    .inFirst      (inFirst),
    .inLast       (inLast),
    .inError      (inError),
    .outReady     (outReady),
    .inReady      (inReady),
    .outValid     (outValid),
    .strb         (strb)
  );

  tagger_datapath #(
    .ADDR_W   (ADDR_W),
    .BASE_LSB (BASE_LSB),
    .CHAN_W   (CHAN_W),
    .OFS_LSB  (OFS_LSB),
    .OFS_W    (OFS_W)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inData     (inData),
    .baseHi     (cfgBase[ADDR_W-1:BASE_LSB]),
    .cfgChannel (cfgChannel),
    .cfgDesc    (cfgDesc),
    .outAddr    (outAddr),
    .outData    (outData)
  );
endmodule

// File: rtl/tagger_checker.sv
module tagger_checker #(
  parameter int ADDR_W   = 40,
  parameter int BASE_LSB = 20,
  parameter int CHAN_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cfgBase,
  input logic [CHAN_W-1:0] cfgChannel,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [ADDR_W-1:0] outAddr,
  input logic [255:0]      outData
);
  localparam int TYPE_LSB = BASE_LSB - CHAN_W - 2;
  localparam int CNT_LSB  = TYPE_LSB - 5;

  logic [4:0]   cntField;
  logic         isEnd;
  logic [255:0] tailMask;
  logic         unusedCfgLow;

  assign unusedCfgLow = ^cfgBase[BASE_LSB-1:0];
  assign cntField     = outAddr[CNT_LSB +: 5];
  assign isEnd        = outAddr[TYPE_LSB + 1];
  assign tailMask     = ~((256'(1) << (32'(cntField) * 8)) - 256'(1));

  assert_low_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> outAddr[CNT_LSB-1:0] == '0);

  assert_base_chan_R2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outAddr[ADDR_W-1:BASE_LSB] == cfgBase[ADDR_W-1:BASE_LSB]) &&
                 (outAddr[BASE_LSB-1:TYPE_LSB+2] == cfgChannel));

  assert_mid_count_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !isEnd) |-> cntField == 5'd0);

  assert_tail_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && isEnd && cntField != 5'd0) |-> (outData & tailMask) == '0);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outAddr) && $stable(outData));

  assert_no_accept_R9: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);
endmodule

bind pkt_block_tagger tagger_checker #(
  .ADDR_W   (ADDR_W),
  .BASE_LSB (BASE_LSB),
  .CHAN_W   (CHAN_W)
) chk_i (.*);

// File: tb/pkt_block_tagger_tb_top.sv
module pkt_block_tagger_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [39:0]  cfgBase = 40'h0;
  logic [1:0]   cfgChannel = 2'd0;
  logic         cfgPrependEn = 1'b0;
  logic [63:0]  cfgDesc = 64'h0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [7:0]   inData = 8'h0;
  logic         inFirst = 1'b0;
  logic         inLast = 1'b0;
  logic         inError = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [39:0]  outAddr;
  logic [255:0] outData;

  always #4 clk = ~clk;  // 125 MHz

  pkt_block_tagger dut_i (.*);

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  int readyMode = 0;
  logic [7:0] lfsr = 8'hA5;

  logic [7:0]   pkt [256];
  logic [39:0]  expAddr [$];
  logic [255:0] expData [$];
  bit           expMask [$];
  logic [39:0]  gotAddr [$];
  logic [255:0] gotData [$];

  // Output side: choose ready, then record blocks taken at the next edge.
  always @(negedge clk) begin
    case (readyMode)
      0: outReady = 1'b1;
      1: outReady = lfsr[0] ^ lfsr[3];
      default: outReady = 1'b0;
    endcase
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (rstN && outValid && outReady) begin
      gotAddr.push_back(outAddr);
      gotData.push_back(outData);
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input bit f, input bit l, input bit e);
    inValid = 1'b1; inData = d; inFirst = f; inLast = l; inError = e;
    forever begin
      if (inReady) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    inValid = 1'b0; inFirst = 1'b0; inLast = 1'b0; inError = 1'b0;
  endtask

  task automatic fillPkt(input int len, input int seed);
    for (int i = 0; i < len; i++) pkt[i] = 8'(seed + i * 37) | 8'h01;
  endtask

  task automatic sendPacket(input int len, input bit err);
    for (int i = 0; i < len; i++)
      sendByte(pkt[i], i == 0, i == len - 1, err && (i == len - 1));
  endtask

  // Expected blocks computed from the requirements.
  task automatic buildExp(input int len, input bit pre, input logic [63:0] desc,
                          input bit err);
    int total = len + (pre ? 8 : 0);
    int nb = (total + 31) / 32;
    logic [63:0] dm = desc & ~64'h1f;
    for (int b = 0; b < nb; b++) begin
      logic [255:0] d = '0;
      int valid = (total - 32 * b > 32) ? 32 : total - 32 * b;
      bit last = (b == nb - 1);
      logic [1:0] t;
      logic [4:0] c;
      for (int k = 0; k < valid; k++) begin
        int s = 32 * b + k;
        if (pre && s < 8) d[8*k +: 8] = dm[8*s +: 8];
        else d[8*k +: 8] = pkt[s - (pre ? 8 : 0)];
      end
      t = last ? {1'b1, err} : ((b == 0) ? 2'b01 : 2'b00);
      c = last ? 5'(valid % 32) : 5'd0;
      expAddr.push_back({cfgBase[39:20], cfgChannel, t, c, 11'b0});
      expData.push_back(d);
      expMask.push_back(pre && b == 0);
    end
  endtask

  task automatic drainCompare(input string req);
    int n;
    for (int w = 0; w < 3000; w++) begin
      if (gotAddr.size() >= expAddr.size() && !outValid) break;
      @(negedge clk);
    end
    check(gotAddr.size() == expAddr.size(), req, "block count",
          256'(gotAddr.size()), 256'(expAddr.size()));
    n = (gotAddr.size() < expAddr.size()) ? gotAddr.size() : expAddr.size();
    for (int i = 0; i < n; i++) begin
      logic [255:0] m = expMask[i] ? ~256'h1f : ~256'h0;
      check(gotAddr[i] == expAddr[i], req, $sformatf("block %0d address", i),
            256'(gotAddr[i]), 256'(expAddr[i]));
      check((gotData[i] & m) == (expData[i] & m), req,
            $sformatf("block %0d data", i), gotData[i], expData[i]);
    end
    gotAddr.delete(); gotData.delete();
    expAddr.delete(); expData.delete(); expMask.delete();
  endtask

  task automatic runPacket(input string req, input int len, input int seed,
                           input bit err);
    fillPkt(len, seed);
    buildExp(len, cfgPrependEn, cfgDesc, err);
    sendPacket(len, err);
    drainCompare(req);
  endtask

  task automatic testReset();
    check(outValid == 1'b0, "R11", "outValid after reset", 256'(outValid), 256'(0));
    check(inReady == 1'b1, "R11", "inReady after reset", 256'(inReady), 256'(1));
  endtask

  task automatic testMultiBlock();
    cfgPrependEn = 1'b0; cfgDesc = 64'hDEAD_BEEF_CAFE_F00D;  // R8: desc ignored
    runPacket("R1/R3/R4/R6/R8", 70, 3, 1'b0);
    runPacket("R3/R4", 64, 11, 1'b1);   // exact boundary, error end
  endtask

  task automatic testSingleBlock();
    runPacket("R5/R4", 5, 21, 1'b0);
    runPacket("R5/R4", 32, 29, 1'b1);   // full single block: count 0
    runPacket("R5/R6", 1, 40, 1'b0);
  endtask

  task automatic testPrepend();
    cfgPrependEn = 1'b1; cfgDesc = 64'h1122_3344_5566_77FF;
    runPacket("R7", 40, 5, 1'b0);
    runPacket("R7/R5", 3, 9, 1'b1);
    runPacket("R7/R4", 24, 13, 1'b0);   // descriptor + data fill one block
    cfgPrependEn = 1'b0;
  endtask

  task automatic testChannelBase();
    cfgBase = 40'hAB_CDE1_2345; cfgChannel = 2'd3;
    runPacket("R2", 33, 17, 1'b0);
    cfgBase = 40'h12_3450_0000; cfgChannel = 2'd1;
    runPacket("R2", 7, 19, 1'b1);
  endtask

  task automatic testStall();
    logic [39:0] a0;
    logic [255:0] d0;
    readyMode = 2;
    fillPkt(40, 61);
    buildExp(40, 1'b0, 64'h0, 1'b0);
    fork
      sendPacket(40, 1'b0);
      begin
        while (!outValid) @(negedge clk);
        a0 = outAddr; d0 = outData;
        repeat (6) @(negedge clk);
        check(outValid && outAddr == a0, "R9", "held address",
              256'(outAddr), 256'(a0));
        check(outData == d0, "R9", "held data", outData, d0);
        check(inReady == 1'b0, "R9", "input held off", 256'(inReady), 256'(0));
        readyMode = 1;
      end
    join
    drainCompare("R9");
    runPacket("R9", 100, 71, 1'b1);
    cfgPrependEn = 1'b1; cfgDesc = 64'h0F0E_0D0C_0B0A_0908;
    runPacket("R9/R7", 90, 77, 1'b0);
    cfgPrependEn = 1'b0;
    readyMode = 0;
  endtask

  task automatic testStray();
    sendByte(8'hEE, 1'b0, 1'b0, 1'b0);
    sendByte(8'hDD, 1'b0, 1'b1, 1'b0);
    sendByte(8'hCC, 1'b0, 1'b0, 1'b0);
    repeat (4) @(negedge clk);
    check(gotAddr.size() == 0, "R10", "no block from stray bytes",
          256'(gotAddr.size()), 256'(0));
    runPacket("R10", 10, 83, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R9 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    cfgBase = 40'h55_5550_0000; cfgChannel = 2'd2;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testMultiBlock();
    testSingleBlock();
    testPrepend();
    testChannelBase();
    testStall();
    testStray();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule